// File: doc/BRIEF.md
# Low-Frequency Transponder Downlink Sequencer

This block drives the reader-to-tag command path of a 125 kHz read/write transponder by switching the reader carrier on and off. A command is framed as a carrier-off start gap, then a series of bits, each sent as a carrier-on interval whose length gives the bit value and closed by a fixed carrier-off gap. After the last bit comes a field-on phase that depends on the command: a long programming hold for a write, or a short extra gap followed by a carrier left on (so that a separate receiver can capture the reply) for a read or a reset.

All durations are counted in field clocks. A single-cycle clock enable `fc_tick` marks each field clock (one every 8 µs at 125 kHz); the sequencer advances only on cycles where it is high, so the system clock rate does not matter. The host places the command fields on the inputs and pulses `start`; the fields are captured at that edge, and `done` pulses once when the sequence has finished.

Top module: `lf_downlink_seq`

## Requirements
- R1: After reset, `carrier_on` and `done` are 0, and while idle with the carrier off and no `start` the carrier stays off.
- R2: A `start` accepted while idle turns the carrier off at that clock edge (even if it was held on) and keeps it off for exactly 50 field clocks.
- R3: A 0 bit is 18 field clocks of carrier on, a 1 bit is 54 field clocks of carrier on, and every bit is followed by 20 field clocks of carrier off.
- R4: `cmd` 2'b00 is reset and sends only the opcode bits 0,0; 2'b01 is write and sends opcode 1,0; 2'b10 and 2'b11 are read and send 1 then `page_sel`.
- R5: For write and read, when `pwd_en` is 1 the 32-bit `pwd` is sent most significant bit first directly after the opcode; when 0 no password bits are sent. Reset never sends a password.
- R6: A write sends, after the opcode and optional password, `lock_bit`, then `wr_data[31:0]` MSB first, then `blk_num[2:0]` MSB first (bits 7:3 are ignored).
- R7: A read sends `blk_num[2:0]` MSB first after the optional password, except when `blk_num` is 8'hFF, in which case no block bits are sent (configuration-register read).
- R8: After the last bit gap of a write, the carrier is on for 2500 field clocks (20 ms), then turns off at the same edge at which `done` pulses.
- R9: After the last bit gap of a read or reset, the carrier stays off for 15 more field clocks, then turns on at the same edge at which `done` pulses, and stays on until the next accepted `start`.
- R10: All durations are counted in `fc_tick` cycles only; while `fc_tick` is low the carrier does not change during a command.
- R11: A `start` while a command is in progress is ignored, and each accepted command produces exactly one single-cycle `done` pulse, with the block idle in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_tick | input | 1 | One-cycle pulse per field clock |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd | input | 2 | Command: 00 reset, 01 write, 1x read |
| page_sel | input | 1 | Page bit for a read opcode |
| blk_num | input | 8 | Block number; 8'hFF on a read selects register read |
| wr_data | input | 32 | Data word for a write |
| pwd | input | 32 | Password |
| pwd_en | input | 1 | Send the password |
| lock_bit | input | 1 | Lock bit for a write |
| carrier_on | output | 1 | Reader carrier enable |
| done | output | 1 | One-cycle pulse at command completion |

## Verification
The assertions assume `start` and the command fields are only meaningful at an accepted edge, that `fc_tick` is a plain enable with no minimum spacing, and that reset is held from time zero. The stimulus drives `fc_tick` as a random enable at roughly half density so that every duration is measured in ticks rather than cycles, issues each `start` as a one-cycle pulse, and deliberately pulses `start` with a different command in the middle of a write to exercise the ignore rule. Command fields are drawn at random around directed cases for register read, high block bits and password on and off.

// File: rtl/lfdl_pkg.sv
package lfdl_pkg;

  typedef enum logic [1:0] {
    K_RESET = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2
  } cmd_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_START    = 3'd1,
    PH_BIT_ON   = 3'd2,
    PH_BIT_GAP  = 3'd3,
    PH_POST_GAP = 3'd4,
    PH_PROG     = 3'd5
  } phase_e;

  localparam int ADDR_BITS = 3;
  localparam int OPC_BITS  = 2;

  function automatic cmd_kind_e decode_kind(input logic [1:0] code);
    case (code)
      2'b00:   return K_RESET;
      2'b01:   return K_WRITE;
      default: return K_READ;
    endcase
  endfunction

  // longest frame: opcode, password, lock, data, address
  function automatic int frame_bits(input int pwd_w, input int data_w);
    return OPC_BITS + pwd_w + 1 + data_w + ADDR_BITS;
  endfunction

  function automatic int cnt_width(input int a, input int b);
    return $clog2(a + b + 1);
  endfunction

endpackage

// File: rtl/lfdl_frame_builder.sv
module lfdl_frame_builder
  import lfdl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PWD_W     = 32,
  parameter int BLK_IN_W  = 8,
  parameter int FRAME_MAX = frame_bits(PWD_W, DATA_W),
  parameter int LEN_W     = $clog2(FRAME_MAX + 1)
) (
  input  cmd_kind_e             kind,
  input  logic                  page_sel,
  input  logic [BLK_IN_W-1:0]   blk_num,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [PWD_W-1:0]      pwd,
  input  logic                  pwd_en,
  input  logic                  lock_bit,
  output logic [FRAME_MAX-1:0]  frame,
  output logic [LEN_W-1:0]      frame_len
);

  logic reg_read;
  assign reg_read = (kind == K_READ) && (blk_num == {BLK_IN_W{1'b1}});

  always_comb begin
    int n;
    frame = '0;
    frame[FRAME_MAX-1] = (kind != K_RESET);
    frame[FRAME_MAX-2] = (kind == K_READ) ? page_sel : 1'b0;
    n = OPC_BITS;
    if (pwd_en && (kind != K_RESET)) begin
      for (int i = PWD_W - 1; i >= 0; i--) begin
        frame[FRAME_MAX-1-n] = pwd[i];
        n++;
      end
    end
    if (kind == K_WRITE) begin
      frame[FRAME_MAX-1-n] = lock_bit;
      n++;
      for (int i = DATA_W - 1; i >= 0; i--) begin
        frame[FRAME_MAX-1-n] = wr_data[i];
        n++;
      end
    end
    if ((kind == K_WRITE) || ((kind == K_READ) && !reg_read)) begin
      for (int i = ADDR_BITS - 1; i >= 0; i--) begin
        frame[FRAME_MAX-1-n] = blk_num[i];
        n++;
      end
    end
    frame_len = LEN_W'(n);
  end

endmodule

// File: rtl/lfdl_tick_timer.sv
module lfdl_tick_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fc_tick,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  assign last = run && fc_tick && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || last) cnt_q <= '0;
    else if (fc_tick)           cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/lfdl_sequencer.sv
module lfdl_sequencer
  import lfdl_pkg::*;
#(
  parameter int FRAME_MAX   = 70,
  parameter int LEN_W       = 7,
  parameter int CNT_W       = 12,
  parameter int START_FC    = 50,
  parameter int ZERO_FC     = 18,
  parameter int ONE_FC      = 54,
  parameter int GAP_FC      = 20,
  parameter int READ_GAP_FC = 15,
  parameter int PROG_FC     = 2500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  cmd_kind_e            kind_in,
  input  logic [FRAME_MAX-1:0] frame_in,
  input  logic [LEN_W-1:0]     len_in,
  input  logic                 t_last,
  output logic                 run,
  output logic [CNT_W-1:0]     limit,
  output logic                 carrier_on,
  output logic                 done,
  output logic                 latched_write
);

  phase_e               ph_q;
  logic [FRAME_MAX-1:0] frame_q;
  logic [LEN_W-1:0]     left_q;
  logic                 carrier_q;
  logic                 done_q;
  logic                 wr_q;
  logic                 cur_bit;

  assign cur_bit       = frame_q[FRAME_MAX-1];
  assign run           = (ph_q != PH_IDLE);
  assign carrier_on    = carrier_q;
  assign done          = done_q;
  assign latched_write = wr_q;

  always_comb begin
    case (ph_q)
      PH_START:    limit = CNT_W'(START_FC);
      PH_BIT_ON:   limit = cur_bit ? CNT_W'(ONE_FC) : CNT_W'(ZERO_FC);
      PH_BIT_GAP:  limit = CNT_W'(GAP_FC);
      PH_POST_GAP: limit = CNT_W'(READ_GAP_FC);
      PH_PROG:     limit = CNT_W'(PROG_FC);
      default:     limit = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      frame_q   <= '0;
      left_q    <= '0;
      carrier_q <= 1'b0;
      done_q    <= 1'b0;
      wr_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q      <= PH_START;
          carrier_q <= 1'b0;
          frame_q   <= frame_in;
          left_q    <= len_in;
          wr_q      <= (kind_in == K_WRITE);
        end
        PH_START: if (t_last) begin
          ph_q      <= PH_BIT_ON;
          carrier_q <= 1'b1;
        end
        PH_BIT_ON: if (t_last) begin
          ph_q      <= PH_BIT_GAP;
          carrier_q <= 1'b0;
        end
        PH_BIT_GAP: if (t_last) begin
          if (left_q > LEN_W'(1)) begin
            frame_q   <= frame_q << 1;
            left_q    <= left_q - LEN_W'(1);
            ph_q      <= PH_BIT_ON;
            carrier_q <= 1'b1;
          end else if (wr_q) begin
            ph_q      <= PH_PROG;
            carrier_q <= 1'b1;
          end else begin
            ph_q      <= PH_POST_GAP;
          end
        end
        PH_POST_GAP: if (t_last) begin
          ph_q      <= PH_IDLE;
          carrier_q <= 1'b1;
          done_q    <= 1'b1;
        end
        PH_PROG: if (t_last) begin
          ph_q      <= PH_IDLE;
          carrier_q <= 1'b0;
          done_q    <= 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lf_downlink_seq.sv
module lf_downlink_seq
  import lfdl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PWD_W       = 32,
  parameter int BLK_IN_W    = 8,
  parameter int START_FC    = 50,
  parameter int ZERO_FC     = 18,
  parameter int ONE_FC      = 54,
  parameter int GAP_FC      = 20,
  parameter int READ_GAP_FC = 15,
  parameter int PROG_FC     = 2500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fc_tick,
  input  logic                start,
  input  logic [1:0]          cmd,
  input  logic                page_sel,
  input  logic [BLK_IN_W-1:0] blk_num,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [PWD_W-1:0]    pwd,
  input  logic                pwd_en,
  input  logic                lock_bit,
  output logic                carrier_on,
  output logic                done
);

  localparam int FRAME_MAX = frame_bits(PWD_W, DATA_W);
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);
  localparam int CNT_W     = cnt_width(PROG_FC + START_FC, ONE_FC + GAP_FC);

  cmd_kind_e            kind;
  logic [FRAME_MAX-1:0] frame;
  logic [LEN_W-1:0]     frame_len;
  logic [CNT_W-1:0]     limit;
  logic                 timer_last;
  logic                 seq_busy;
  logic                 kind_write;

  assign kind = decode_kind(cmd);

  lfdl_frame_builder #(
    .DATA_W(DATA_W), .PWD_W(PWD_W), .BLK_IN_W(BLK_IN_W),
    .FRAME_MAX(FRAME_MAX), .LEN_W(LEN_W)
  ) u_builder (
    .kind(kind), .page_sel(page_sel), .blk_num(blk_num),
    .wr_data(wr_data), .pwd(pwd), .pwd_en(pwd_en), .lock_bit(lock_bit),
    .frame(frame), .frame_len(frame_len)
  );

  lfdl_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(seq_busy), .fc_tick(fc_tick),
    .limit(limit), .last(timer_last)
  );

  lfdl_sequencer #(
    .FRAME_MAX(FRAME_MAX), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .START_FC(START_FC), .ZERO_FC(ZERO_FC), .ONE_FC(ONE_FC),
    .GAP_FC(GAP_FC), .READ_GAP_FC(READ_GAP_FC), .PROG_FC(PROG_FC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .kind_in(kind),
    .frame_in(frame), .len_in(frame_len), .t_last(timer_last),
    .run(seq_busy), .limit(limit), .carrier_on(carrier_on),
    .done(done), .latched_write(kind_write)
  );

endmodule

// File: rtl/lfdl_checks.sv
module lfdl_checks (
  input logic clk,
  input logic rst_n,
  input logic fc_tick,
  input logic start,
  input logic carrier_on,
  input logic done,
  input logic busy,
  input logic is_write
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !carrier_on && !start) |=> !carrier_on);

  p_start_field_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!carrier_on && busy));

  p_write_ends_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_write) |-> !carrier_on);

  p_read_ends_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_write) |-> carrier_on);

  p_hold_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && carrier_on) |=> carrier_on);

  p_no_tick_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fc_tick) |=> $stable(carrier_on));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(is_write));

endmodule

bind lf_downlink_seq lfdl_checks u_lfdl_checks (
  .clk(clk), .rst_n(rst_n), .fc_tick(fc_tick), .start(start),
  .carrier_on(carrier_on), .done(done), .busy(seq_busy), .is_write(kind_write)
);

// File: tb/test_lf_downlink_seq.sv
`timescale 1ns/1ps
module test_lf_downlink_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fc_tick = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic        page_sel = 1'b0;
  logic [7:0]  blk_num = 8'h00;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] pwd = 32'h0;
  logic        pwd_en = 1'b0;
  logic        lock_bit = 1'b0;
  logic        carrier_on;
  logic        done;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lf_downlink_seq i_lf_downlink_seq (
    .clk(clk), .rst_n(rst_n), .fc_tick(fc_tick), .start(start), .cmd(cmd),
    .page_sel(page_sel), .blk_num(blk_num), .wr_data(wr_data), .pwd(pwd),
    .pwd_en(pwd_en), .lock_bit(lock_bit), .carrier_on(carrier_on), .done(done)
  );

  // random field-clock enable, changed away from the active edge
  always @(negedge clk) begin
    cyc++;
    fc_tick = rst_n && ($urandom_range(0, 99) < 55);
  end

  // waveform recorder: run lengths in field clocks
  bit rec_arm = 0;
  bit recording = 0;
  int act_lvl[0:199];
  int act_len[0:199];
  int act_n = 0;
  int cur_lvl = 0;
  int cur_len = 0;
  int done_cnt = 0;

  always begin
    bit t, s;
    @(posedge clk);
    t = fc_tick;
    s = start;
    #1;
    if (done) done_cnt++;
    if (rec_arm && s) begin
      rec_arm = 0;
      recording = 1;
      act_n = 0;
      cur_lvl = 0;
      cur_len = 0;
      n_checks++;
      if (carrier_on !== 1'b0) begin
        n_fail++;
        $display("FAIL R2 carrier at start edge: actual %0b expected 0", carrier_on);
      end
    end else if (recording) begin
      if (t) cur_len++;
      if (int'(carrier_on) != cur_lvl) begin
        if (act_n < 200) begin
          act_lvl[act_n] = cur_lvl;
          act_len[act_n] = cur_len;
          act_n++;
        end
        cur_lvl = int'(carrier_on);
        cur_len = 0;
      end
      if (done) recording = 0;
    end
  end

  // expected bit stream and segments
  bit exp_b[0:127];
  int exp_nb;
  int exp_lvl[0:199];
  int exp_len[0:199];
  int exp_n;

  function automatic void push_bits(input logic [31:0] v, input int w);
    for (int k = w - 1; k >= 0; k--) begin
      exp_b[exp_nb] = v[k];
      exp_nb++;
    end
  endfunction

  function automatic void push_seg(input int lvl, input int len);
    exp_lvl[exp_n] = lvl;
    exp_len[exp_n] = len;
    exp_n++;
  endfunction

  function automatic void model(input logic [1:0] c, input logic pg, input logic [7:0] b,
                                input logic [31:0] d, input logic [31:0] pw,
                                input logic pe, input logic lk);
    bit is_wr, is_rd;
    is_wr = (c == 2'b01);
    is_rd = c[1];
    exp_nb = 0;
    exp_n = 0;
    if (is_wr)      push_bits(32'b10, 2);
    else if (is_rd) push_bits({31'b0, 1'b1} << 1 | {31'b0, pg}, 2);
    else            push_bits(32'b00, 2);
    if (pe && (is_wr || is_rd)) push_bits(pw, 32);
    if (is_wr) begin
      push_bits({31'b0, lk}, 1);
      push_bits(d, 32);
      push_bits({29'b0, b[2:0]}, 3);
    end else if (is_rd && b != 8'hFF) begin
      push_bits({29'b0, b[2:0]}, 3);
    end
    push_seg(0, 50);
    for (int k = 0; k < exp_nb; k++) begin
      push_seg(1, exp_b[k] ? 54 : 18);
      if (k == exp_nb - 1 && !is_wr) push_seg(0, 20 + 15);
      else                           push_seg(0, 20);
    end
    if (is_wr) push_seg(1, 2500);
  endfunction

  task automatic run_cmd(input logic [1:0] c, input logic pg, input logic [7:0] b,
                         input logic [31:0] d, input logic [31:0] pw,
                         input logic pe, input logic lk, input bit poke,
                         input string tags);
    int w;
    int bad;
    model(c, pg, b, d, pw, pe, lk);
    @(negedge clk);
    cmd = c; page_sel = pg; blk_num = b; wr_data = d; pwd = pw;
    pwd_en = pe; lock_bit = lk;
    done_cnt = 0;
    rec_arm = 1;
    start = 1'b1;
    w = 0;
    do begin
      @(negedge clk);
      w++;
      if (poke && w == 300) begin
        start = 1'b1;
        cmd = 2'b00;
        blk_num = ~b;
        pwd_en = ~pe;
      end else begin
        start = 1'b0;
      end
    end while ((recording || rec_arm) && w < 60000);
    // waveform comparison
    n_checks++;
    bad = -1;
    if (w >= 60000) bad = 999;
    else if (act_n != exp_n) bad = 998;
    else
      for (int k = 0; k < exp_n; k++)
        if (bad < 0 && (act_lvl[k] != exp_lvl[k] || act_len[k] != exp_len[k])) bad = k;
    if (bad == 999) begin
      n_fail++;
      $display("FAIL R3 R10 %s: command never finished, actual timeout expected done", tags);
    end else if (bad == 998) begin
      n_fail++;
      $display("FAIL R3 R10 %s: segment count actual %0d expected %0d", tags, act_n, exp_n);
    end else if (bad >= 0) begin
      n_fail++;
      $display("FAIL R3 R10 %s: segment %0d actual lvl %0d len %0d expected lvl %0d len %0d",
               tags, bad, act_lvl[bad], act_len[bad], exp_lvl[bad], exp_len[bad]);
    end
    // hold behaviour and single done
    repeat (30) @(negedge clk);
    n_checks++;
    if (done_cnt != 1) begin
      n_fail++;
      $display("FAIL R11 %s: done pulses actual %0d expected 1", tags, done_cnt);
    end
    n_checks++;
    if (carrier_on !== (c == 2'b01 ? 1'b0 : 1'b1)) begin
      n_fail++;
      $display("FAIL %s %s: idle carrier actual %0b expected %0b", tags,
               (c == 2'b01) ? "R8" : "R9", carrier_on, (c == 2'b01) ? 1'b0 : 1'b1);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cyc == 199000 && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R1: reset state
    n_checks++;
    if (carrier_on !== 1'b0) begin
      n_fail++; $display("FAIL R1 carrier after reset: actual %0b expected 0", carrier_on);
    end
    n_checks++;
    if (done !== 1'b0) begin
      n_fail++; $display("FAIL R1 done after reset: actual %0b expected 0", done);
    end
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    n_checks++;
    if (carrier_on !== 1'b0) begin
      n_fail++; $display("FAIL R1 idle carrier: actual %0b expected 0", carrier_on);
    end

    // directed corner cases
    run_cmd(2'b00, 1'b1, 8'h07, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b1, 0, "R4 R5 R9 reset");
    run_cmd(2'b10, 1'b0, 8'h05, 32'h0, 32'h0,         1'b0, 1'b0, 0, "R4 R7 R9 read p0");
    run_cmd(2'b11, 1'b1, 8'h0D, 32'h0, 32'h0,         1'b0, 1'b0, 0, "R4 R7 read p1 mask");
    run_cmd(2'b10, 1'b1, 8'hFF, 32'h0, 32'h0,         1'b0, 1'b0, 0, "R7 register read");
    run_cmd(2'b10, 1'b0, 8'hFF, 32'h0, 32'hA5C3_0F81, 1'b1, 1'b0, 0, "R5 R7 register read pwd");
    run_cmd(2'b01, 1'b0, 8'hFB, 32'h8000_0001, 32'h0, 1'b0, 1'b1, 0, "R4 R6 R8 write");
    run_cmd(2'b01, 1'b1, 8'h02, 32'h3C5A_F00F, 32'h1234_5678, 1'b1, 1'b0, 1, "R5 R6 R8 R11 write pwd");

    // constrained random reads and one write
    for (int k = 0; k < 6; k++) begin
      logic [7:0] rb;
      rb = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
      run_cmd({1'b1, 1'($urandom)}, 1'($urandom), rb, 32'($urandom), 32'($urandom),
              1'($urandom), 1'($urandom), 0, "R5 R7 R9 random read");
    end
    run_cmd(2'b01, 1'b0, 8'($urandom), 32'($urandom), 32'($urandom), 1'b0, 1'($urandom),
            0, "R6 R8 random write");
    summary();
  end

endmodule